// File: doc/BRIEF.md
# Chainable Serial Command Slave

This block is the serial front end of a device that is controlled by 16-bit command frames. A host lowers the frame strobe, clocks command bits in most-significant bit first on the serial data input, and raises the strobe to end the frame. Every bit passes through a 16-bit shift register whose top bit drives the serial output. Several slaves can therefore be wired output-to-input in a chain, and one long transfer then loads all of them at once.

The serial pins are oversampled by a system clock. When the strobe rises, the block checks the frame. It discards frames whose clock count is not a whole number of 16-bit words, and frames made only of ones. An accepted frame produces a single-cycle write strobe that carries a 4-bit command code and a 10-bit data field. The serial output can be released to a high-impedance state by a two-frame sequence, 0x8001 followed by 0x0000. The next accepted frame drives it again.

Top module: `dcs_frame_slave`

## Requirements
- R1: After reset, `sdo_oe` is 1, `sdo` is 0, no write strobe is issued, and the shift register holds all zeros, so the first frame after reset shifts out sixteen 0 bits.
- R2: `din` is sampled on each falling edge of `sclk` while `sync_n` is low and enters bit 0 of the 16-bit shift register while the other bits move one place toward bit 15. `sclk` edges while `sync_n` is high change nothing.
- R3: If `sync_n` rises after a count of `sclk` falling edges that is zero or not a multiple of 16, the frame is discarded. There is no write strobe and no change to the high-impedance state or to the state of the entry sequence. The shift register keeps the bits shifted in.
- R4: If `sync_n` rises after a nonzero multiple of 16 falling edges, and the register is not all ones, the frame is accepted. `wr_stb` is high for exactly one `clk` cycle, `wr_cmd` is register bits [13:10] and `wr_data` is bits [9:0]. Bits [15:14] take no part in decoding.
- R5: In a frame longer than 16 clocks, only the last 16 bits shifted in are evaluated.
- R6: A frame whose 16 evaluated bits are all ones (0xFFFF) is invalid. It produces no strobe and changes neither the high-impedance state nor the entry-sequence state.
- R7: `sdo` loads bit 15 of the shift register when `sync_n` falls and on each rising edge of `sclk` within a frame. The first 16 bits a frame shifts out are therefore the previous register contents, most significant bit first.
- R8: An accepted frame 0x8001 followed by an accepted frame 0x0000, with no other accepted frame between them, drives `sdo_oe` to 0. Discarded frames between the two do not break the sequence.
- R9: While `sdo_oe` is 0, the next accepted frame sets `sdo_oe` to 1 and is executed with its own write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial bit clock |
| sync_n | input | 1 | Active-low frame strobe |
| din | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, bit 15 of the shift register |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high impedance |
| wr_stb | output | 1 | One-cycle write strobe for an accepted frame |
| wr_cmd | output | 4 | Command code of the accepted frame |
| wr_data | output | 10 | Data field of the accepted frame |

## Verification
The hardest states to reach are in the high-impedance entry sequence. Its armed state cannot be seen at the ports, and it has to survive frames that are discarded for being short or all ones, yet be broken by any other accepted frame. The stimulus reaches these states by sending 0x8001 and then, before 0x0000, a frame that is short, all ones, or an ordinary command, and it reads `sdo_oe` after each one. The shift-register contents are checked bit by bit on `sdo` in the frame that follows, so that bits left behind by short frames and by long frames can be seen.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int FRAME_W = 16;
  localparam int CMD_W   = 4;
  localparam int DATA_W  = 10;
  localparam int CMD_LSB = 10;
  localparam int SYNC_STAGES = 2;
  localparam logic [FRAME_W-1:0] SEQ_ARM  = 16'h8001;
  localparam logic [FRAME_W-1:0] SEQ_FIRE = 16'h0000;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] data;
  } wr_t;
endpackage

// File: rtl/dcs_in_sync.sv
module dcs_in_sync #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o
);
  logic [STAGES-1:0][N-1:0] st_q, st_d;

  always_comb begin
    st_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) st_d[s] = st_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {STAGES{IDLE}};
    else        st_q <= st_d;
  end

  assign lvl_o = st_q[STAGES-1];
endmodule

// File: rtl/dcs_edge.sv
module dcs_edge #(
  parameter int N = 1,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/dcs_shifter.sv
module dcs_shifter
  import dcs_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_frame,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          frame_start,
  input  logic          din,
  output logic [FW-1:0] frame_o,
  output logic          len_ok_o,
  output logic          sdo_o
);
  localparam int CNT_W = (FW > 1) ? $clog2(FW) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FW - 1);

  logic [FW-1:0]    sreg_q, sreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;
  logic             sdo_q, sdo_d;
  logic             shift_en, out_en;

  assign shift_en = in_frame & sclk_fall;
  assign out_en   = (in_frame & sclk_rise) | frame_start;

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    wrap_d = wrap_q;
    sdo_d  = sdo_q;
    if (frame_start) begin
      cnt_d  = '0;
      wrap_d = 1'b0;
    end else if (shift_en) begin
      sreg_d = {sreg_q[FW-2:0], din};
      if (cnt_q == CNT_LAST) begin
        cnt_d  = '0;
        wrap_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
    if (out_en) sdo_d = sreg_q[FW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      sdo_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
      sdo_q  <= sdo_d;
    end
  end

  assign frame_o  = sreg_q;
  assign len_ok_o = wrap_q & (cnt_q == '0);
  assign sdo_o    = sdo_q;

  // R3: a new frame starts with an empty count, so a short tail cannot pass.
  a_r3_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!len_ok_o && cnt_q == '0));

  // R2: no shifting while the strobe is high.
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && !frame_start) |=> $stable(frame_o));
endmodule

// File: rtl/dcs_decode.sv
module dcs_decode
  import dcs_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int CW = CMD_W,
  parameter int DW = DATA_W,
  parameter int CL = CMD_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_end,
  input  logic          len_ok,
  input  logic [FW-1:0] frame,
  output logic          wr_stb_o,
  output wr_t           wr_o,
  output logic          sdo_oe_o
);
  logic stb_q, stb_d;
  wr_t  wr_q, wr_d;
  logic arm_q, arm_d;
  logic hiz_q, hiz_d;
  logic accept;

  assign accept = frame_end & len_ok & (frame != '1);

  always_comb begin
    stb_d = accept;
    wr_d  = wr_q;
    arm_d = arm_q;
    hiz_d = hiz_q;
    if (accept) begin
      wr_d.cmd  = frame[CL+CW-1:CL];
      wr_d.data = frame[DW-1:0];
      arm_d     = (frame == SEQ_ARM);
      if (hiz_q)                             hiz_d = 1'b0;
      else if (arm_q && frame == SEQ_FIRE)   hiz_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      wr_q  <= '0;
      arm_q <= 1'b0;
      hiz_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
      wr_q  <= wr_d;
      arm_q <= arm_d;
      hiz_q <= hiz_d;
    end
  end

  assign wr_stb_o = stb_q;
  assign wr_o     = wr_q;
  assign sdo_oe_o = ~hiz_q;

  // R4: the strobe lasts one cycle.
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  // R3: a badly sized frame leaves strobe and output mode alone.
  a_r3_short_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !len_ok) |=> (!wr_stb_o && $stable(sdo_oe_o)));

  // R6: all-ones frames change nothing.
  a_r6_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && frame == '1) |=> (!wr_stb_o && $stable(sdo_oe_o) && $stable(arm_q)));

  // R8: release only after the closing frame of the sequence.
  a_r8_hiz_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe_o) |-> ($past(frame_end) && $past(frame) == SEQ_FIRE && wr_stb_o));

  // R9: leaving high impedance comes with an executed command.
  a_r9_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe_o) |-> wr_stb_o);
endmodule

// File: rtl/dcs_frame_slave.sv
module dcs_frame_slave
  import dcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              din,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              wr_stb,
  output logic [CMD_W-1:0]  wr_cmd,
  output logic [DATA_W-1:0] wr_data
);
  // bit 0: sclk (idles low), bit 1: sync_n (idles high)
  localparam logic [1:0] CTRL_IDLE = 2'b10;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [1:0] ctrl_lvl, ctrl_rise, ctrl_fall;
  logic [0:0] din_lvl;
  logic [FRAME_W-1:0] frame;
  logic len_ok;
  wr_t  wr;

  dcs_in_sync #(.N(2), .STAGES(SYNC_STAGES), .IDLE(CTRL_IDLE)) ctrl_sync_i (
    .clk(clk), .rst_n(rst_n_s), .async_i({sync_n, sclk}), .lvl_o(ctrl_lvl));

  dcs_in_sync #(.N(1), .STAGES(SYNC_STAGES), .IDLE(1'b0)) din_sync_i (
    .clk(clk), .rst_n(rst_n_s), .async_i(din), .lvl_o(din_lvl));

  dcs_edge #(.N(2), .IDLE(CTRL_IDLE)) ctrl_edge_i (
    .clk(clk), .rst_n(rst_n_s), .lvl_i(ctrl_lvl),
    .rise_o(ctrl_rise), .fall_o(ctrl_fall));

  dcs_shifter #(.FW(FRAME_W)) shifter_i (
    .clk(clk), .rst_n(rst_n_s),
    .in_frame(~ctrl_lvl[1]),
    .sclk_rise(ctrl_rise[0]),
    .sclk_fall(ctrl_fall[0]),
    .frame_start(ctrl_fall[1]),
    .din(din_lvl[0]),
    .frame_o(frame), .len_ok_o(len_ok), .sdo_o(sdo));

  dcs_decode #(.FW(FRAME_W), .CW(CMD_W), .DW(DATA_W), .CL(CMD_LSB)) decode_i (
    .clk(clk), .rst_n(rst_n_s),
    .frame_end(ctrl_rise[1]), .len_ok(len_ok), .frame(frame),
    .wr_stb_o(wr_stb), .wr_o(wr), .sdo_oe_o(sdo_oe));

  assign wr_cmd  = wr.cmd;
  assign wr_data = wr.data;
endmodule

// File: tb/dcs_frame_slave_tb_top.sv
module dcs_frame_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic sync_n = 1'b1;
  logic din = 1'b0;
  logic sdo, sdo_oe, wr_stb;
  logic [3:0] wr_cmd;
  logic [9:0] wr_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [13:0] exp_q[$];
  logic [15:0] model_sreg = '0;

  always #5 clk = ~clk;

  dcs_frame_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
    .sdo(sdo), .sdo_oe(sdo_oe), .wr_stb(wr_stb), .wr_cmd(wr_cmd), .wr_data(wr_data));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every strobe must match the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 R6 unexpected strobe actual %h expected none", {wr_cmd, wr_data});
      end else begin
        logic [13:0] e;
        e = exp_q.pop_front();
        if ({wr_cmd, wr_data} != e) begin
          errors++;
          $display("FAIL R4 write actual %h expected %h", {wr_cmd, wr_data}, e);
        end
      end
    end
  end

  task automatic idle_clocks(input int n);
    din = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk = 1'b1;
      repeat (6) @(negedge clk); sclk = 1'b0;
      repeat (6) @(negedge clk);
    end
    din = 1'b0;
  endtask

  // Driver: sends n bits (last n of bits, MSB first), checks shifted-out
  // bits against the bench model, pushes the expected write.
  task automatic send(input logic [31:0] bits, input int n, input string req);
    logic [15:0] prev;
    logic [15:0] cap;
    int k;
    prev = model_sreg;
    cap = '0;
    @(negedge clk); sync_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      din = bits[n-1-i];
      @(negedge clk); sclk = 1'b1;
      repeat (5) @(negedge clk);
      if (i < 16) cap[15-i] = sdo;
      @(negedge clk); sclk = 1'b0;
      repeat (6) @(negedge clk);
      model_sreg = {model_sreg[14:0], bits[n-1-i]};
    end
    if (n > 0 && (n % 16) == 0 && model_sreg != 16'hFFFF)
      exp_q.push_back({model_sreg[13:10], model_sreg[9:0]});
    sync_n = 1'b1;
    repeat (12) @(negedge clk);
    k = (n < 16) ? n : 16;
    if (k > 0)
      chk((cap >> (16 - k)) == (prev >> (16 - k)), {"R7 shifted-out bits ", req},
          32'(cap >> (16 - k)), 32'(prev >> (16 - k)));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R1 reset state
    chk(sdo_oe == 1'b1, "R1 sdo_oe after reset", 32'(sdo_oe), 1);
    chk(sdo == 1'b0, "R1 sdo after reset", 32'(sdo), 0);

    send(32'h2155, 16, "R1 first frame shifts zeros");
    send(32'hC3A5, 16, "R4 top bits ignored");
    idle_clocks(8);  // R2 clocks with strobe high
    send(32'h1234, 16, "R2 idle clocks ignored");
    send(32'h05A5, 11, "R3 short frame");
    send(32'h0F0F, 16, "R3 kept bits of short frame");
    send(32'hABCDE, 20, "R5 long frame");
    send(32'h00F00D1, 32, "R5 two-word frame");
    send(32'hFFFF, 16, "R6 all ones");
    chk(sdo_oe == 1'b1, "R6 all ones keeps drive", 32'(sdo_oe), 1);
    send(32'h0, 0, "R3 empty frame");

    // R8 plain entry
    send(32'h8001, 16, "R8 arm");
    chk(sdo_oe == 1'b1, "R8 arm alone keeps drive", 32'(sdo_oe), 1);
    send(32'h0000, 16, "R8 fire");
    chk(sdo_oe == 1'b0, "R8 high impedance entered", 32'(sdo_oe), 0);
    send(32'hFFFF, 16, "R6 all ones in hiz");
    chk(sdo_oe == 1'b0, "R6 all ones does not wake", 32'(sdo_oe), 0);
    send(32'h0155, 9, "R3 short in hiz");
    chk(sdo_oe == 1'b0, "R3 short frame does not wake", 32'(sdo_oe), 0);
    send(32'h2000, 16, "R9 wake");
    chk(sdo_oe == 1'b1, "R9 accepted frame wakes", 32'(sdo_oe), 1);

    // R8 broken by an accepted frame in between
    send(32'h8001, 16, "R8 arm b");
    send(32'h1234, 16, "R8 breaker");
    send(32'h0000, 16, "R8 late fire");
    chk(sdo_oe == 1'b1, "R8 interrupted sequence keeps drive", 32'(sdo_oe), 1);

    // R8 discarded frames do not break it
    send(32'h8001, 16, "R8 arm c");
    send(32'h0033, 7, "R3 short between");
    send(32'h0000, 16, "R8 fire c");
    chk(sdo_oe == 1'b0, "R8 short frame between keeps sequence", 32'(sdo_oe), 0);
    send(32'h8001, 16, "R9 wake with arm");
    chk(sdo_oe == 1'b1, "R9 arm frame wakes", 32'(sdo_oe), 1);
    send(32'hFFFF, 16, "R6 all ones between");
    send(32'h0000, 16, "R8 fire d");
    chk(sdo_oe == 1'b0, "R6 all ones between keeps sequence", 32'(sdo_oe), 0);
    send(32'h2000, 16, "R9 final wake");
    chk(sdo_oe == 1'b1, "R9 final wake", 32'(sdo_oe), 1);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected writes seen", 32'(exp_q.size()), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule